// File: doc/BRIEF.md
# Heading-Relative Operand Selector

This block sits inside each compute cell of a two-dimensional mesh. Every cell receives an 8-bit value from each of its four compass neighbours. A downstream function unit does not ask for "the north value" or "the east value". It asks for its arguments by relative direction: Left, Right, Front or Back. These directions are measured from a rotatable heading held in two bits.

The selector does two things. First, it turns the heading into a map from relative directions to absolute neighbour ports. Second, it uses a 4-bit selection code to route one or two of those neighbours onto operand outputs `a` and `b`. Each operand output has its own valid flag. Rewriting only the heading turns the cell: every argument moves to a new neighbour while the selection code stays the same.

By default the operands are captured in a register that loads when the enable input is high. A parameter removes that register and leaves a purely combinational path.

Top module: `cell_operand_selector`

## Requirements
- R1: The heading encoding is 0=North, 1=East, 2=South, 3=West. Front is the neighbour in the heading direction and Back is the opposite neighbour.
- R2: Left and Right depend on the heading as follows: North gives Left=West and Right=East; East gives Left=North and Right=South; South gives Left=East and Right=West; West gives Left=South and Right=North.
- R3: Selection codes 0 to 5 are two-operand selections. They place (a,b) = (L,R), (L,F), (L,B), (F,R), (B,R) and (F,B) in that code order, with both valid flags high.
- R4: Selection codes 6 to 9 are single-operand selections. They place L, R, F or B respectively on a with the a-valid flag high, while b is zero and the b-valid flag is low.
- R5: Selection codes 10 to 15 drive both operands to zero with both valid flags low.
- R6: In the default registered build, the operands and flags appear on the outputs after the rising clock edge at which `en` is high. The build with no output register keeps the same selection rules.
- R7: While `en` is low, the outputs keep their values whatever the neighbour, heading and selection inputs do.
- R8: A synchronous active-high `rst` clears both operands and both valid flags at the next rising edge, and takes precedence over `en`.
- R9: With the selection code held, changing only the heading re-targets the operands to the neighbours given by R1 and R2 for the new heading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Load enable for the output register |
| nbr_n | input | 8 | Value from the north neighbour |
| nbr_e | input | 8 | Value from the east neighbour |
| nbr_s | input | 8 | Value from the south neighbour |
| nbr_w | input | 8 | Value from the west neighbour |
| heading | input | 2 | Cell heading (0=N, 1=E, 2=S, 3=W) |
| op_sel | input | 4 | Operand selection code |
| opnd_a | output | 8 | First operand |
| opnd_b | output | 8 | Second operand |
| opnd_a_vld | output | 1 | First operand carries a selected value |
| opnd_b_vld | output | 1 | Second operand carries a selected value |

## Verification
The hardest case to produce from the ports is one where a wrong relative-to-absolute mapping still yields the expected value. That happens whenever two neighbours carry equal data, or when the heading is never rotated under a fixed code. To rule this out, every neighbour carries a distinct value that also changes from vector to vector. The vector table then walks all four headings under the same codes, so a swapped Left/Right or Front/Back mapping shows up as a wrong value. Directed steps hold the selection code while only the heading moves. They also change every input while `en` is low, and assert reset together with `en` to confirm that reset wins.

// File: rtl/cellsel_pkg.sv
package cellsel_pkg;

    localparam int unsigned NUM_DIRS = 4;
    localparam int unsigned SEL_W    = 4;

    typedef logic [1:0] dir_t;

    typedef enum logic [1:0] {
        HD_NORTH = 2'd0,
        HD_EAST  = 2'd1,
        HD_SOUTH = 2'd2,
        HD_WEST  = 2'd3
    } heading_e;

    typedef enum logic [1:0] {
        REL_LEFT  = 2'd0,
        REL_RIGHT = 2'd1,
        REL_FRONT = 2'd2,
        REL_BACK  = 2'd3
    } rel_e;

    typedef struct packed {
        dir_t left;
        dir_t right;
        dir_t front;
        dir_t back;
    } relmap_t;

    typedef struct packed {
        logic a_vld;
        logic b_vld;
        rel_e a_rel;
        rel_e b_rel;
    } seldec_t;

    localparam logic [SEL_W-1:0] SEL_LR     = 4'd0;
    localparam logic [SEL_W-1:0] SEL_LF     = 4'd1;
    localparam logic [SEL_W-1:0] SEL_LB     = 4'd2;
    localparam logic [SEL_W-1:0] SEL_FR     = 4'd3;
    localparam logic [SEL_W-1:0] SEL_BR     = 4'd4;
    localparam logic [SEL_W-1:0] SEL_FB     = 4'd5;
    localparam logic [SEL_W-1:0] SEL_L      = 4'd6;
    localparam logic [SEL_W-1:0] SEL_R      = 4'd7;
    localparam logic [SEL_W-1:0] SEL_F      = 4'd8;
    localparam logic [SEL_W-1:0] SEL_B      = 4'd9;
    localparam logic [SEL_W-1:0] SEL_LAST_OK = SEL_B;

    // Quarter turns clockwise from the heading: 0 front, 1 right, 2 back, 3 left.
    function automatic dir_t turn_cw(input heading_e hd, input logic [1:0] quarters);
        return dir_t'(hd) + quarters;
    endfunction

    function automatic seldec_t decode_sel(input logic [SEL_W-1:0] code);
        seldec_t d;
        d = '{a_vld: 1'b0, b_vld: 1'b0, a_rel: REL_LEFT, b_rel: REL_LEFT};
        case (code)
            SEL_LR: d = '{1'b1, 1'b1, REL_LEFT,  REL_RIGHT};
            SEL_LF: d = '{1'b1, 1'b1, REL_LEFT,  REL_FRONT};
            SEL_LB: d = '{1'b1, 1'b1, REL_LEFT,  REL_BACK};
            SEL_FR: d = '{1'b1, 1'b1, REL_FRONT, REL_RIGHT};
            SEL_BR: d = '{1'b1, 1'b1, REL_BACK,  REL_RIGHT};
            SEL_FB: d = '{1'b1, 1'b1, REL_FRONT, REL_BACK};
            SEL_L:  d = '{1'b1, 1'b0, REL_LEFT,  REL_LEFT};
            SEL_R:  d = '{1'b1, 1'b0, REL_RIGHT, REL_LEFT};
            SEL_F:  d = '{1'b1, 1'b0, REL_FRONT, REL_LEFT};
            SEL_B:  d = '{1'b1, 1'b0, REL_BACK,  REL_LEFT};
            default: ;
        endcase
        return d;
    endfunction

    function automatic dir_t rel_to_dir(input relmap_t m, input rel_e r);
        dir_t d;
        case (r)
            REL_LEFT:  d = m.left;
            REL_RIGHT: d = m.right;
            REL_FRONT: d = m.front;
            default:   d = m.back;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cellsel_heading_map.sv
module cellsel_heading_map
    import cellsel_pkg::*;
(
    input  heading_e hd,
    output relmap_t  map
);

    always_comb begin
        map.front = turn_cw(hd, 2'd0);
        map.right = turn_cw(hd, 2'd1);
        map.back  = turn_cw(hd, 2'd2);
        map.left  = turn_cw(hd, 2'd3);
    end

    // The four relative directions must cover all four ports exactly once.
    logic [NUM_DIRS-1:0] covered;
    always_comb begin
        covered = '0;
        covered[map.left]  = 1'b1;
        covered[map.right] = 1'b1;
        covered[map.front] = 1'b1;
        covered[map.back]  = 1'b1;
        if (!$isunknown(hd))
            AST_MAP_IS_PERMUTATION: assert ($countones(covered) == NUM_DIRS); // R1
    end

endmodule

// File: rtl/cellsel_route.sv
module cellsel_route
    import cellsel_pkg::*;
#(
    parameter int unsigned DW = 8
)(
    input  logic [NUM_DIRS-1:0][DW-1:0] nbr,
    input  relmap_t                     map,
    input  logic [SEL_W-1:0]            sel,
    output logic [DW-1:0]               a,
    output logic [DW-1:0]               b,
    output logic                        a_vld,
    output logic                        b_vld
);

    seldec_t dec;
    dir_t    a_dir;
    dir_t    b_dir;

    always_comb begin
        dec   = decode_sel(sel);
        a_dir = rel_to_dir(map, dec.a_rel);
        b_dir = rel_to_dir(map, dec.b_rel);
        a_vld = dec.a_vld;
        b_vld = dec.b_vld;
        a     = dec.a_vld ? nbr[a_dir] : '0;
        b     = dec.b_vld ? nbr[b_dir] : '0;
    end

endmodule

// File: rtl/cellsel_stage.sv
module cellsel_stage #(
    parameter int unsigned DW      = 8,
    parameter bit          OUT_REG = 1'b1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    input  logic          a_vld_in,
    input  logic          b_vld_in,
    output logic [DW-1:0] a_out,
    output logic [DW-1:0] b_out,
    output logic          a_vld_out,
    output logic          b_vld_out
);

    generate
        if (OUT_REG) begin : g_reg
            logic [DW-1:0] a_q, b_q;
            logic          av_q, bv_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    a_q  <= '0;
                    b_q  <= '0;
                    av_q <= 1'b0;
                    bv_q <= 1'b0;
                end else if (en) begin
                    a_q  <= a_in;
                    b_q  <= b_in;
                    av_q <= a_vld_in;
                    bv_q <= b_vld_in;
                end
            end

            assign a_out     = a_q;
            assign b_out     = b_q;
            assign a_vld_out = av_q;
            assign b_vld_out = bv_q;

            AST_SYNC_CLEAR: assert property (@(posedge clk)
                rst |=> (a_out == '0 && b_out == '0 && !a_vld_out && !b_vld_out)); // R8

            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
                !en |=> ($stable(a_out) && $stable(b_out)
                         && $stable(a_vld_out) && $stable(b_vld_out))); // R7

            AST_LOAD_ON_EN: assert property (@(posedge clk) disable iff (rst)
                en |=> (a_out == $past(a_in) && b_out == $past(b_in))); // R6
        end else begin : g_comb
            logic unused_ctl;
            assign unused_ctl = clk ^ rst ^ en;
            assign a_out      = a_in;
            assign b_out      = b_in;
            assign a_vld_out  = a_vld_in;
            assign b_vld_out  = b_vld_in;
        end
    endgenerate

endmodule

// File: rtl/cell_operand_selector.sv
module cell_operand_selector
    import cellsel_pkg::*;
#(
    parameter int unsigned DW      = 8,
    parameter bit          OUT_REG = 1'b1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DW-1:0]    nbr_n,
    input  logic [DW-1:0]    nbr_e,
    input  logic [DW-1:0]    nbr_s,
    input  logic [DW-1:0]    nbr_w,
    input  logic [1:0]       heading,
    input  logic [SEL_W-1:0] op_sel,
    output logic [DW-1:0]    opnd_a,
    output logic [DW-1:0]    opnd_b,
    output logic             opnd_a_vld,
    output logic             opnd_b_vld
);

    logic [NUM_DIRS-1:0][DW-1:0] nbr;
    relmap_t                     map;
    logic [DW-1:0]               ra, rb;
    logic                        ra_vld, rb_vld;

    // Port index order follows the heading encoding so that turns are modular adds.
    assign nbr[HD_NORTH] = nbr_n;
    assign nbr[HD_EAST]  = nbr_e;
    assign nbr[HD_SOUTH] = nbr_s;
    assign nbr[HD_WEST]  = nbr_w;

    cellsel_heading_map u_map (
        .hd  (heading_e'(heading)),
        .map (map)
    );

    cellsel_route #(.DW(DW)) u_route (
        .nbr   (nbr),
        .map   (map),
        .sel   (op_sel),
        .a     (ra),
        .b     (rb),
        .a_vld (ra_vld),
        .b_vld (rb_vld)
    );

    cellsel_stage #(.DW(DW), .OUT_REG(OUT_REG)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .a_in      (ra),
        .b_in      (rb),
        .a_vld_in  (ra_vld),
        .b_vld_in  (rb_vld),
        .a_out     (opnd_a),
        .b_out     (opnd_b),
        .a_vld_out (opnd_a_vld),
        .b_vld_out (opnd_b_vld)
    );

    AST_B_NEEDS_A: assert property (@(posedge clk) disable iff (rst)
        opnd_b_vld |-> opnd_a_vld); // R4

    AST_INVALID_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!opnd_a_vld |-> opnd_a == '0) and (!opnd_b_vld |-> opnd_b == '0)); // R5

    AST_UNUSED_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (op_sel > SEL_LAST_OK) |-> (!ra_vld && !rb_vld && ra == '0 && rb == '0)); // R5

    AST_DUAL_BOTH_VALID: assert property (@(posedge clk) disable iff (rst)
        (op_sel <= SEL_FB) |-> (ra_vld && rb_vld)); // R3

endmodule

// File: tb/sim_cell_operand_selector.sv
module sim_cell_operand_selector;

    localparam int DW = 8;
    localparam int NV = 23;
    localparam logic [2:0] NONE = 3'd7;

    // {heading[11:10], sel[9:6], exp_a_dir[5:3], exp_b_dir[2:0]}; dir 0=N 1=E 2=S 3=W 7=zero
    localparam logic [11:0] VEC [NV] = '{
        {2'd0, 4'd0, 3'd3, 3'd1}, {2'd0, 4'd1, 3'd3, 3'd0}, {2'd0, 4'd2, 3'd3, 3'd2},
        {2'd0, 4'd3, 3'd0, 3'd1}, {2'd0, 4'd4, 3'd2, 3'd1}, {2'd0, 4'd5, 3'd0, 3'd2},
        {2'd0, 4'd6, 3'd3, NONE}, {2'd0, 4'd7, 3'd1, NONE}, {2'd0, 4'd8, 3'd0, NONE},
        {2'd0, 4'd9, 3'd2, NONE}, {2'd1, 4'd0, 3'd0, 3'd2}, {2'd1, 4'd5, 3'd1, 3'd3},
        {2'd1, 4'd1, 3'd0, 3'd1}, {2'd2, 4'd0, 3'd1, 3'd3}, {2'd2, 4'd3, 3'd2, 3'd3},
        {2'd2, 4'd9, 3'd0, NONE}, {2'd3, 4'd0, 3'd2, 3'd0}, {2'd3, 4'd4, 3'd1, 3'd0},
        {2'd3, 4'd2, 3'd2, 3'd1}, {2'd3, 4'd8, 3'd3, NONE}, {2'd0, 4'd10, NONE, NONE},
        {2'd3, 4'd15, NONE, NONE}, {2'd1, 4'd12, NONE, NONE}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [DW-1:0] nbr_n = '0, nbr_e = '0, nbr_s = '0, nbr_w = '0;
    logic [1:0]    heading = '0;
    logic [3:0]    op_sel = '0;
    logic [DW-1:0] opnd_a, opnd_b;
    logic          opnd_a_vld, opnd_b_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cell_operand_selector u0 (
        .clk(clk), .rst(rst), .en(en),
        .nbr_n(nbr_n), .nbr_e(nbr_e), .nbr_s(nbr_s), .nbr_w(nbr_w),
        .heading(heading), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .opnd_a_vld(opnd_a_vld), .opnd_b_vld(opnd_b_vld)
    );

    function automatic logic [DW-1:0] pick(input logic [2:0] d);
        case (d)
            3'd0: return nbr_n;
            3'd1: return nbr_e;
            3'd2: return nbr_s;
            3'd3: return nbr_w;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got a=%h b=%h va=%b vb=%b, expected a=%h b=%h va=%b vb=%b",
                     req, got[17:10], got[9:2], got[1], got[0],
                     exp[17:10], exp[9:2], exp[1], exp[0]);
        end
    endtask

    function automatic logic [17:0] outs();
        return {opnd_a, opnd_b, opnd_a_vld, opnd_b_vld};
    endfunction

    function automatic logic [17:0] expect_of(input logic [2:0] da, input logic [2:0] db);
        return {pick(da), pick(db), da != NONE, db != NONE};
    endfunction

    task automatic set_nbrs(input int seed);
        nbr_n = 8'h10 + 8'(seed);
        nbr_e = 8'h40 + 8'(seed);
        nbr_s = 8'h80 + 8'(seed);
        nbr_w = 8'hC0 + 8'(seed);
    endtask

    logic [17:0] held;

    initial begin
        // reset state (R8)
        repeat (3) @(negedge clk);
        check("R8 reset state", outs(), 18'h0);
        rst = 1'b0;
        en  = 1'b1;

        // vector walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_nbrs(i);
            heading = VEC[i][11:10];
            op_sel  = VEC[i][9:6];
            @(negedge clk);
            check(VEC[i][9:6] > 4'd9 ? "R5 unused code" :
                  VEC[i][9:6] > 4'd5 ? "R4 single operand" : "R1 R2 R3 dual map",
                  outs(), expect_of(VEC[i][5:3], VEC[i][2:0]));
        end

        // R6: output changes only after the capturing edge
        @(negedge clk);
        set_nbrs(50); heading = 2'd0; op_sel = 4'd0;
        @(negedge clk);
        held = outs();
        heading = 2'd2;
        @(posedge clk); #1;
        check("R6 load after edge", outs(), expect_of(3'd1, 3'd3));
        @(negedge clk);
        check("R6 held before load", held, expect_of(3'd3, 3'd1));

        // R9: only heading rotates, selection held at F,B
        op_sel = 4'd5;
        for (int h = 0; h < 4; h++) begin
            @(negedge clk);
            heading = 2'(h);
            @(negedge clk);
            check("R9 rotate F,B", outs(),
                  expect_of(3'(h), 3'((h + 2) % 4)));
        end

        // R7: en low, change everything
        en = 1'b0;
        held = outs();
        @(negedge clk);
        set_nbrs(99); heading = 2'd1; op_sel = 4'd7;
        repeat (3) @(negedge clk);
        check("R7 hold while idle", outs(), held);
        en = 1'b1;
        @(negedge clk);
        check("R7 resume load", outs(), expect_of(3'd2, NONE));

        // R8: reset wins over enable
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset over enable", outs(), 18'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reload after reset", outs(), expect_of(3'd2, NONE));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule